// File: doc/BRIEF.md
# Carry-Select Adder, Eight Bits

This block adds two 8-bit unsigned operands and a carry-in, and returns an 8-bit sum and a carry-out. It has no clock or state. It is meant for datapaths where the carry chain limits the clock period and a modest amount of extra logic is acceptable to shorten it.

The lower nibble comes from one 4-bit adder fed with the real carry-in. The upper nibble is computed twice at the same time, while the lower carry is still settling. One copy assumes an incoming carry of 0 and the other assumes an incoming carry of 1. The lower nibble's carry-out then drives a bank of five 2:1 multiplexers. Four of them choose the upper sum bits and one chooses the final carry-out. That carry therefore selects a finished result and never ripples through the upper half.

A small select unit turns the lower carry into a struct of per-multiplexer pick strobes. The datapath holds the three nibble adders and the multiplexer bank.

Top module: `csaAdder8`

## Requirements
- R1: `sumOut` equals (`opA` + `opB` + `carryIn`) mod 256 for every operand pair and both carry-in values.
- R2: `carryOut` equals bit 8 of the 9-bit result of `opA` + `opB` + `carryIn`.
- R3: `sumOut[3:0]` depends only on `opA[3:0]`, `opB[3:0]` and `carryIn`. Changing only the upper operand bits leaves it unchanged.
- R4: When `opA[3:0]` + `opB[3:0]` + `carryIn` is below 16 (lower carry 0), `sumOut[7:4]` and `carryOut` come from the upper adder that assumes carry 0. That is, {`carryOut`, `sumOut[7:4]`} = `opA[7:4]` + `opB[7:4]`.
- R5: When that lower total is 16 or more (lower carry 1), {`carryOut`, `sumOut[7:4]`} = `opA[7:4]` + `opB[7:4]` + 1, taken from the upper adder that assumes carry 1.
- R6: A carry produced in the lower nibble and propagated across all upper bits is delivered correctly. For example, 0xFF + 0x00 + 1 gives sum 0x00 with carry-out 1, and 0x0F + 0x01 + 0 gives 0x10 with carry-out 0.
- R7: The outputs match a behavioural 8-bit add for all 131072 combinations of operands and carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 8 | Sum, modulo 256 |
| carryOut | output | 1 | Carry out of bit 7 |

## Verification
The embedded checks re-evaluate the following relations each time the logic settles:
- each nibble adder against arithmetic;
- the two upper candidates against each other, which must differ by exactly one;
- every pick strobe against the lower carry;
- the full 9-bit result against a behavioural add.

Independence of the lower nibble from the upper operand bits, and the choice between candidates across both carry regimes, are shown only by the bench's paired and classified stimulus. The bench also sweeps every input combination exhaustively.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int CSA_WIDTH = 8;
  localparam int CSA_LOW_W = CSA_WIDTH / 2;
  localparam int CSA_HIGH_W = CSA_WIDTH - CSA_LOW_W;

  // one strobe per output multiplexer: upper sum bits plus the carry-out
  typedef struct packed {
    logic [CSA_HIGH_W-1:0] sumPick;
    logic coutPick;
  } csaStrobes_t;
endpackage

// File: rtl/csaNibbleAdder.sv
module csaNibbleAdder #(
  parameter int W = 4
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         addCin,
  output logic [W-1:0] addSum,
  output logic         addCout
);
  logic [W:0]   chain;
  logic [W-1:0] prop;
  logic [W-1:0] gen;

  assign chain[0] = addCin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign prop[i]    = addA[i] ^ addB[i];
      assign gen[i]     = addA[i] & addB[i];
      assign addSum[i]  = prop[i] ^ chain[i];
      assign chain[i+1] = gen[i] | (prop[i] & chain[i]);
    end
  endgenerate

  assign addCout = chain[W];

  // R1: bit-level chain must agree with an arithmetic add of the slice
  always_comb begin
    a_r1_nibble_exact: assert ({addCout, addSum} ==
                               ({1'b0, addA} + {1'b0, addB} + {{W{1'b0}}, addCin}))
      else $error("nibble adder mismatch");
  end
endmodule

// File: rtl/csaSelectCtrl.sv
module csaSelectCtrl
  import csa_pkg::*;
(
  input  logic        lowCarry,
  output csaStrobes_t strobes
);
  always_comb begin
    strobes.sumPick  = {CSA_HIGH_W{lowCarry}};
    strobes.coutPick = lowCarry;
  end
endmodule

// File: rtl/csaDatapath.sv
module csaDatapath
  import csa_pkg::*;
(
  input  logic [CSA_WIDTH-1:0]  dpA,
  input  logic [CSA_WIDTH-1:0]  dpB,
  input  logic                  dpCin,
  input  csaStrobes_t           strobes,
  output logic                  lowCarry,
  output logic [CSA_WIDTH-1:0]  dpSum,
  output logic                  dpCout
);
  logic [CSA_LOW_W-1:0]  lowSum;
  logic [CSA_HIGH_W-1:0] hiSum0, hiSum1;
  logic                  hiCout0, hiCout1;

  csaNibbleAdder #(.W(CSA_LOW_W)) uLow (
    .addA(dpA[CSA_LOW_W-1:0]), .addB(dpB[CSA_LOW_W-1:0]), .addCin(dpCin),
    .addSum(lowSum), .addCout(lowCarry)
  );

  csaNibbleAdder #(.W(CSA_HIGH_W)) uHiZero (
    .addA(dpA[CSA_WIDTH-1:CSA_LOW_W]), .addB(dpB[CSA_WIDTH-1:CSA_LOW_W]), .addCin(1'b0),
    .addSum(hiSum0), .addCout(hiCout0)
  );

  csaNibbleAdder #(.W(CSA_HIGH_W)) uHiOne (
    .addA(dpA[CSA_WIDTH-1:CSA_LOW_W]), .addB(dpB[CSA_WIDTH-1:CSA_LOW_W]), .addCin(1'b1),
    .addSum(hiSum1), .addCout(hiCout1)
  );

  assign dpSum[CSA_LOW_W-1:0] = lowSum;

  genvar j;
  generate
    for (j = 0; j < CSA_HIGH_W; j++) begin : g_mux
      assign dpSum[CSA_LOW_W+j] = strobes.sumPick[j] ? hiSum1[j] : hiSum0[j];
    end
  endgenerate

  assign dpCout = strobes.coutPick ? hiCout1 : hiCout0;

  always_comb begin
    // R5: the speculative pair differs by exactly one
    a_r5_pair_offset: assert ({hiCout1, hiSum1} == {hiCout0, hiSum0} + 1'b1)
      else $error("upper candidates not one apart");
    // R4: every pick strobe follows the lower carry
    a_r4_strobe_track: assert (strobes.sumPick == {CSA_HIGH_W{lowCarry}} &&
                               strobes.coutPick == lowCarry)
      else $error("strobe disagrees with lower carry");
    // R4: with lower carry clear, the upper result is the carry-0 candidate
    if (!lowCarry) begin
      a_r4_pick_zero: assert ({dpCout, dpSum[CSA_WIDTH-1:CSA_LOW_W]} == {hiCout0, hiSum0})
        else $error("carry-0 candidate not selected");
    end
  end
endmodule

// File: rtl/csaAdder8.sv
module csaAdder8
  import csa_pkg::*;
(
  input  logic [7:0] opA,
  input  logic [7:0] opB,
  input  logic       carryIn,
  output logic [7:0] sumOut,
  output logic       carryOut
);
  logic        lowCarry;
  csaStrobes_t strobes;

  csaDatapath uDp (
    .dpA(opA), .dpB(opB), .dpCin(carryIn), .strobes(strobes),
    .lowCarry(lowCarry), .dpSum(sumOut), .dpCout(carryOut)
  );

  csaSelectCtrl uCtrl (
    .lowCarry(lowCarry), .strobes(strobes)
  );

  always_comb begin
    // R2: full 9-bit result equals the behavioural add
    a_r2_total: assert ({carryOut, sumOut} == ({1'b0, opA} + {1'b0, opB} + {8'd0, carryIn}))
      else $error("adder result mismatch");
  end
endmodule

// File: tb/sim_csaAdder8.sv
module sim_csaAdder8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opA = '0, opB = '0;
  logic       carryIn = 1'b0;
  logic [7:0] sumOut;
  logic       carryOut;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  csaAdder8 u0 (.opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut));

  function automatic logic [8:0] refAdd(logic [7:0] a, logic [7:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {8'd0, c};
  endfunction

  task automatic apply(logic [7:0] a, logic [7:0] b, logic c);
    @(posedge clk);
    opA = a; opB = b; carryIn = c;
    @(negedge clk);
  endtask

  task automatic check(string req, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h c=%b got=%h exp=%h", req, opA, opB, carryIn, got, exp);
    end
  endtask

  initial begin
    logic [8:0] e;
    logic [4:0] lowTot;
    logic [3:0] keepLow;
    int unused;
    unused = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset-state zero", {carryOut, sumOut}, 9'd0);

    // R6 directed corner cases
    apply(8'hFF, 8'h00, 1'b1); check("R6", {carryOut, sumOut}, 9'h100);
    apply(8'h0F, 8'h01, 1'b0); check("R6", {carryOut, sumOut}, 9'h010);
    apply(8'hFF, 8'hFF, 1'b1); check("R6", {carryOut, sumOut}, 9'h1FF);
    apply(8'hF0, 8'h0F, 1'b1); check("R6", {carryOut, sumOut}, 9'h100);

    // R1 R2 R4 R5 random vectors
    for (int k = 0; k < 400; k++) begin
      apply(8'($urandom), 8'($urandom), 1'($urandom));
      e = refAdd(opA, opB, carryIn);
      check("R1", {1'b0, sumOut}, {1'b0, e[7:0]});
      check("R2", {8'd0, carryOut}, {8'd0, e[8]});
      lowTot = {1'b0, opA[3:0]} + {1'b0, opB[3:0]} + {4'd0, carryIn};
      if (lowTot < 5'd16)
        check("R4", {4'd0, carryOut, sumOut[7:4]}, {4'd0, 5'({1'b0, opA[7:4]} + {1'b0, opB[7:4]})});
      else
        check("R5", {4'd0, carryOut, sumOut[7:4]}, {4'd0, 5'({1'b0, opA[7:4]} + {1'b0, opB[7:4]} + 5'd1)});
    end

    // R3 lower nibble unaffected by upper operand bits
    for (int k = 0; k < 40; k++) begin
      apply(8'($urandom), 8'($urandom), 1'($urandom));
      keepLow = sumOut[3:0];
      apply({4'($urandom), opA[3:0]}, {4'($urandom), opB[3:0]}, carryIn);
      check("R3", {5'd0, sumOut[3:0]}, {5'd0, keepLow});
    end

    // R7 exhaustive sweep
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          apply(8'(a), 8'(b), 1'(c));
          check("R7", {carryOut, sumOut}, refAdd(8'(a), 8'(b), 1'(c)));
        end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule